// File: doc/BRIEF.md
# System Control Register File

This block is the system-control register bank of a processor core. The core reaches it through coprocessor move instructions. Each access presents a primary register number, a secondary selector (CRm), a 3-bit opcode_2 selector, a read/write flag and a 32-bit data word.

The bank holds the following state:
- a device ID word and a cache-type word, both fixed by parameter;
- a control word whose bits drive the memory-system enables;
- a translation table base and the domain permission word;
- separate data-side and prefetch-side fault status bytes;
- a fault address;
- a process identifier;
- data-side and instruction-side lockdown words for both the caches and the TLBs.

Register 7 and register 8 store nothing. A write to either one is decoded into a numbered cache or TLB command. That command leaves the block as a one-cycle strobe and carries the written word as its address operand.

A single access state machine shapes all responses. Each accepted access moves it into exactly one response state for one cycle:
- `ST_IDLE`: no response.
- `ST_RDATA`: read data is valid.
- `ST_RUNDEF`: an undefined read; returns zero and raises the undefined flag.
- `ST_WUNDEF`: an undefined write; raises the undefined flag only.
- `ST_CACHE`: a cache command strobe.
- `ST_TLB`: a TLB command strobe.

The state returns to `ST_IDLE` on the next cycle unless another access arrives. Transitions:
- No access, a legal register write, or a write to register 7 or 8 with an unknown selector pair goes to `ST_IDLE`.
- A legal read goes to `ST_RDATA`.
- An illegal read goes to `ST_RUNDEF`.
- An illegal write goes to `ST_WUNDEF`.
- A decoded register 7 write goes to `ST_CACHE`.
- A decoded register 8 write goes to `ST_TLB`.

Top module: `sysctl_regfile`

## Requirements
- R1: Reading register 0 with opcode_2 = 1 returns parameter CTYPE_WORD. Any other opcode_2 returns parameter ID_WORD. Writes to register 0 change neither value and raise no flag.
- R2: A read accepted at a clock edge gives rd_valid = 1 and rd_data in the following cycle only. Back-to-back reads give back-to-back results. After reset all strobes and flags are 0.
- R3: Register 1 (control) stores bits 31:30, 14:12, 9:7 and 2:0. It always reads bits 6:3 as 1111 and reads bits 11:10 and 29:15 as 0. After reset it reads 0x00000078.
- R4: Control bit 0 drives mmu_en, bit 1 align_chk_en, bit 2 dcache_en, bit 7 big_endian, bit 12 icache_en, bit 13 vec_high and bit 14 rr_repl.
- R5: Registers 2 (translation base), 3 (domain permissions) and 6 (fault address) store and read back all 32 bits and reset to zero. Register 2 drives ttb_base and register 3 drives domain_acl.
- R6: Register 5 with opcode_2 = 0 is the data fault status and with opcode_2 = 1 the prefetch fault status. The two are independent, keep only bits 7:0, read bits 31:8 as zero and reset to zero.
- R7: Register 13 keeps only written bits 31:25. It reads bits 24:0 as zero and resets to zero.
- R8: Registers 9 (cache lockdown) and 10 (TLB lockdown) each hold a data-side copy (opcode_2 = 0) and an instruction-side copy (opcode_2 = 1). All four are 32-bit, independent and reset to zero.
- R9: A write to register 7 pulses cache_cmd_valid for one cycle, with cmd_addr equal to the written word and cmd_op coded from the (CRm, opcode_2) pair:
  - (7,0) → 1, invalidate both caches
  - (5,0) → 2, invalidate instruction cache
  - (5,1) → 3, invalidate one instruction line
  - (13,1) → 4, prefetch an instruction line
  - (6,0) → 5, invalidate data cache
  - (6,1) → 6, invalidate one data line
  - (10,1) → 7, clean a data line
  - (14,1) → 8, clean and invalidate a data line
  - (10,2) → 9, clean a data line by index
  - (14,2) → 10, clean and invalidate a data line by index
  - (10,4) → 11, drain write buffer
  - (0,4) → 12, wait for interrupt
- R10: A write to register 8 pulses tlb_cmd_valid for one cycle, with cmd_addr equal to the written word and cmd_op coded from the (CRm, opcode_2) pair:
  - (7,0) → 1, invalidate both TLBs
  - (5,0) → 2, invalidate instruction TLB
  - (5,1) → 3, invalidate one instruction TLB entry
  - (6,0) → 4, invalidate data TLB
  - (6,1) → 5, invalidate one data TLB entry

  A write to register 7 or 8 with any other pair produces no strobe and no flag.
- R11: The following accesses are undefined:
  - a read of register 4, 7, 8, 11, 12, 14 or 15;
  - any access to register 5, 9 or 10 with opcode_2 above 1.

  An undefined read returns rd_valid = 1, rd_data = 0 and undef_acc = 1 for one cycle. A write to register 4, 11, 12, 14 or 15, or an undefined-selector write to register 5, 9 or 10, changes no state and pulses undef_acc alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary selector |
| acc_op2 | input | 3 | opcode_2 selector |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| undef_acc | output | 1 | Undefined access flag |
| cache_cmd_valid | output | 1 | Cache command strobe |
| tlb_cmd_valid | output | 1 | TLB command strobe |
| cmd_op | output | 4 | Command code |
| cmd_addr | output | 32 | Command address operand |
| mmu_en | output | 1 | Translation enable |
| align_chk_en | output | 1 | Alignment fault enable |
| dcache_en | output | 1 | Data cache enable |
| big_endian | output | 1 | Big-endian operation |
| icache_en | output | 1 | Instruction cache enable |
| vec_high | output | 1 | High exception vector base |
| rr_repl | output | 1 | Round-robin replacement |
| ttb_base | output | 32 | Translation table base |
| domain_acl | output | 32 | Domain permission word |
| proc_id | output | 7 | Process identifier |

## Verification
The bench targets the following corner cases:
- **Selector splits on register 0.** opcode_2 values other than 0 and 1 must still return the ID word. A decoder keyed on opcode_2 = 0 alone would return the wrong word.
- **Fixed control-word fields after an all-ones write.** A plain store would leak ones into bits 11:10 or the reserved range.
- **Paired registers 5, 9 and 10.** Both copies are written with different values and read back. A decode that ignores opcode_2 would show the last value written in both copies.
- **Command decode.** Undefined (CRm, opcode_2) pairs on registers 7 and 8 are sent. A loose decoder would strobe a command on them, and a misplaced pair would give a wrong code.
- **Undefined accesses.** Reads of write-only and test registers, and a bad-selector write whose target is then read back, show whether an undefined access leaks old data or corrupts state.
- **Read pipeline.** Back-to-back reads check for a lost or stretched valid.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned DW = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDATA,
        ST_RUNDEF,
        ST_WUNDEF,
        ST_CACHE,
        ST_TLB
    } acc_state_e;

    // control word: bits kept in storage and bits forced to one on read
    localparam logic [DW-1:0] CTRL_KEEP = 32'hC000_7387;
    localparam logic [DW-1:0] CTRL_ONES = 32'h0000_0078;

    localparam logic [3:0] OP_NONE = 4'd0;

    function automatic logic [3:0] cache_code(input logic [3:0] crm, input logic [2:0] op2);
        case ({crm, op2})
            {4'd7,  3'd0}: cache_code = 4'd1;
            {4'd5,  3'd0}: cache_code = 4'd2;
            {4'd5,  3'd1}: cache_code = 4'd3;
            {4'd13, 3'd1}: cache_code = 4'd4;
            {4'd6,  3'd0}: cache_code = 4'd5;
            {4'd6,  3'd1}: cache_code = 4'd6;
            {4'd10, 3'd1}: cache_code = 4'd7;
            {4'd14, 3'd1}: cache_code = 4'd8;
            {4'd10, 3'd2}: cache_code = 4'd9;
            {4'd14, 3'd2}: cache_code = 4'd10;
            {4'd10, 3'd4}: cache_code = 4'd11;
            {4'd0,  3'd4}: cache_code = 4'd12;
            default:       cache_code = OP_NONE;
        endcase
    endfunction

    function automatic logic [3:0] tlb_code(input logic [3:0] crm, input logic [2:0] op2);
        case ({crm, op2})
            {4'd7, 3'd0}: tlb_code = 4'd1;
            {4'd5, 3'd0}: tlb_code = 4'd2;
            {4'd5, 3'd1}: tlb_code = 4'd3;
            {4'd6, 3'd0}: tlb_code = 4'd4;
            {4'd6, 3'd1}: tlb_code = 4'd5;
            default:      tlb_code = OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_cmd_dec.sv
module sysctl_cmd_dec
    import sysctl_pkg::*;
(
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic [3:0] cache_op,
    output logic [3:0] tlb_op
);
    always_comb begin
        cache_op = cache_code(crm, op2);
        tlb_op   = tlb_code(crm, op2);
    end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_WORD    = 32'h5A01_0C37,
    parameter logic [31:0] CTYPE_WORD = 32'h1C25_A0D2,
    parameter int unsigned FSR_W      = 8,
    parameter int unsigned PID_LSB    = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    crn,
    input  logic [2:0]    op2,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_word,
    output logic          rd_bad,
    output logic          wr_bad,
    output logic [DW-1:0] ctrl_word,
    output logic [DW-1:0] ttb_word,
    output logic [DW-1:0] dacr_word,
    output logic [DW-PID_LSB-1:0] pid_field
);
    localparam int unsigned PID_W = DW - PID_LSB;

    logic [DW-1:0]    ctrl_q, ttb_q, dacr_q, far_q;
    logic [PID_W-1:0] pid_q;
    logic [FSR_W-1:0] fsr_v [2];
    logic [DW-1:0]    clock_v [2];
    logic [DW-1:0]    tlock_v [2];
    logic             pair_ok;

    assign pair_ok = (op2 < 3'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ttb_q  <= '0;
            dacr_q <= '0;
            far_q  <= '0;
            pid_q  <= '0;
        end else if (wr_en) begin
            unique case (crn)
                4'd1:    ctrl_q <= wdata & CTRL_KEEP;
                4'd2:    ttb_q  <= wdata;
                4'd3:    dacr_q <= wdata;
                4'd6:    far_q  <= wdata;
                4'd13:   pid_q  <= wdata[DW-1:PID_LSB];
                default: ;
            endcase
        end
    end

    // data-side (index 0) and instruction/prefetch-side (index 1) copies
    for (genvar g = 0; g < 2; g++) begin : g_side
        logic [FSR_W-1:0] fsr_r;
        logic [DW-1:0]    clk_r;
        logic [DW-1:0]    tlk_r;
        logic             hit;
        assign hit = wr_en && pair_ok && (op2[0] == 1'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fsr_r <= '0;
                clk_r <= '0;
                tlk_r <= '0;
            end else if (hit) begin
                if (crn == 4'd5)  fsr_r <= wdata[FSR_W-1:0];
                if (crn == 4'd9)  clk_r <= wdata;
                if (crn == 4'd10) tlk_r <= wdata;
            end
        end
        assign fsr_v[g]   = fsr_r;
        assign clock_v[g] = clk_r;
        assign tlock_v[g] = tlk_r;
    end

    always_comb begin
        rd_word = '0;
        rd_bad  = 1'b0;
        wr_bad  = 1'b0;
        unique case (crn)
            4'd0:  rd_word = (op2 == 3'd1) ? CTYPE_WORD : ID_WORD;
            4'd1:  rd_word = ctrl_q | CTRL_ONES;
            4'd2:  rd_word = ttb_q;
            4'd3:  rd_word = dacr_q;
            4'd5: begin
                rd_word = pair_ok ? DW'(fsr_v[op2[0]]) : '0;
                rd_bad  = !pair_ok;
                wr_bad  = !pair_ok;
            end
            4'd6:  rd_word = far_q;
            4'd9: begin
                rd_word = pair_ok ? clock_v[op2[0]] : '0;
                rd_bad  = !pair_ok;
                wr_bad  = !pair_ok;
            end
            4'd10: begin
                rd_word = pair_ok ? tlock_v[op2[0]] : '0;
                rd_bad  = !pair_ok;
                wr_bad  = !pair_ok;
            end
            4'd13: rd_word = {pid_q, {PID_LSB{1'b0}}};
            4'd7, 4'd8: rd_bad = 1'b1;
            default: begin
                rd_bad = 1'b1;
                wr_bad = 1'b1;
            end
        endcase
    end

    assign ctrl_word = ctrl_q;
    assign ttb_word  = ttb_q;
    assign dacr_word = dacr_q;
    assign pid_field = pid_q;

    AST_TTB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && crn == 4'd2) |-> $stable(ttb_q)); // R5
    AST_CTRL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[29:15] == '0 && ctrl_q[11:10] == '0); // R3

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_WORD    = 32'h5A01_0C37,
    parameter logic [31:0] CTYPE_WORD = 32'h1C25_A0D2,
    parameter int unsigned FSR_W      = 8,
    parameter int unsigned PID_LSB    = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [3:0]  acc_crn,
    input  logic [3:0]  acc_crm,
    input  logic [2:0]  acc_op2,
    input  logic [31:0] acc_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        undef_acc,
    output logic        cache_cmd_valid,
    output logic        tlb_cmd_valid,
    output logic [3:0]  cmd_op,
    output logic [31:0] cmd_addr,
    output logic        mmu_en,
    output logic        align_chk_en,
    output logic        dcache_en,
    output logic        big_endian,
    output logic        icache_en,
    output logic        vec_high,
    output logic        rr_repl,
    output logic [31:0] ttb_base,
    output logic [31:0] domain_acl,
    output logic [6:0]  proc_id
);
    localparam int unsigned PID_W = DW - PID_LSB;

    acc_state_e    state_q, state_d;
    logic [DW-1:0] payload_q, payload_d;
    logic [3:0]    op_q, op_d;
    logic [DW-1:0] rd_word, ctrl_word;
    logic          rd_bad, wr_bad;
    logic [3:0]    cache_op, tlb_op;
    logic [PID_W-1:0] pid_field;

    sysctl_regs #(
        .ID_WORD(ID_WORD), .CTYPE_WORD(CTYPE_WORD),
        .FSR_W(FSR_W), .PID_LSB(PID_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(acc_valid && acc_write),
        .crn(acc_crn), .op2(acc_op2), .wdata(acc_wdata),
        .rd_word(rd_word), .rd_bad(rd_bad), .wr_bad(wr_bad),
        .ctrl_word(ctrl_word), .ttb_word(ttb_base), .dacr_word(domain_acl),
        .pid_field(pid_field)
    );

    sysctl_cmd_dec u_dec (
        .crm(acc_crm), .op2(acc_op2),
        .cache_op(cache_op), .tlb_op(tlb_op)
    );

    // next-state and captured payload
    always_comb begin
        state_d   = ST_IDLE;
        payload_d = '0;
        op_d      = OP_NONE;
        if (acc_valid) begin
            if (!acc_write) begin
                state_d   = rd_bad ? ST_RUNDEF : ST_RDATA;
                payload_d = rd_bad ? '0 : rd_word;
            end else if (acc_crn == 4'd7) begin
                if (cache_op != OP_NONE) begin
                    state_d   = ST_CACHE;
                    payload_d = acc_wdata;
                    op_d      = cache_op;
                end
            end else if (acc_crn == 4'd8) begin
                if (tlb_op != OP_NONE) begin
                    state_d   = ST_TLB;
                    payload_d = acc_wdata;
                    op_d      = tlb_op;
                end
            end else if (wr_bad) begin
                state_d = ST_WUNDEF;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            payload_q <= '0;
            op_q      <= OP_NONE;
        end else begin
            state_q   <= state_d;
            payload_q <= payload_d;
            op_q      <= op_d;
        end
    end

    // outputs by state
    always_comb begin
        rd_valid        = 1'b0;
        rd_data         = '0;
        undef_acc       = 1'b0;
        cache_cmd_valid = 1'b0;
        tlb_cmd_valid   = 1'b0;
        cmd_op          = OP_NONE;
        cmd_addr        = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RDATA: begin
                rd_valid = 1'b1;
                rd_data  = payload_q;
            end
            ST_RUNDEF: begin
                rd_valid  = 1'b1;
                undef_acc = 1'b1;
            end
            ST_WUNDEF: undef_acc = 1'b1;
            ST_CACHE: begin
                cache_cmd_valid = 1'b1;
                cmd_op          = op_q;
                cmd_addr        = payload_q;
            end
            ST_TLB: begin
                tlb_cmd_valid = 1'b1;
                cmd_op        = op_q;
                cmd_addr      = payload_q;
            end
            default: ;
        endcase
    end

    assign mmu_en       = ctrl_word[0];
    assign align_chk_en = ctrl_word[1];
    assign dcache_en    = ctrl_word[2];
    assign big_endian   = ctrl_word[7];
    assign icache_en    = ctrl_word[12];
    assign vec_high     = ctrl_word[13];
    assign rr_repl      = ctrl_word[14];
    assign proc_id      = 7'(pid_field);

    AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write)); // R2
    AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !undef_acc && $past(acc_crn) == 4'd1)
        |-> (rd_data[6:3] == 4'hF && rd_data[11:10] == 2'b00)); // R3
    AST_FSR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(acc_crn) == 4'd5) |-> rd_data[31:8] == '0); // R6
    AST_PID_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(acc_crn) == 4'd13) |-> rd_data[24:0] == '0); // R7
    AST_CACHE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cache_cmd_valid |-> ($past(acc_valid && acc_write && acc_crn == 4'd7)
                             && cmd_addr == $past(acc_wdata) && cmd_op != OP_NONE)); // R9
    AST_TLB_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_cmd_valid |-> ($past(acc_valid && acc_write && acc_crn == 4'd8)
                           && cmd_addr == $past(acc_wdata) && cmd_op != OP_NONE)); // R10
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, cache_cmd_valid, tlb_cmd_valid})); // R9
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_acc && rd_valid) |-> rd_data == '0); // R11

endmodule

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;

    localparam logic [31:0] IDW = 32'h3B70_11E4;
    localparam logic [31:0] CTW = 32'h0A5C_6D19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_crn = '0, acc_crm = '0;
    logic [2:0]  acc_op2 = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid, undef_acc, cache_cmd_valid, tlb_cmd_valid;
    logic [31:0] rd_data, cmd_addr, ttb_base, domain_acl;
    logic [3:0]  cmd_op;
    logic        mmu_en, align_chk_en, dcache_en, big_endian, icache_en, vec_high, rr_repl;
    logic [6:0]  proc_id;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sysctl_regfile #(.ID_WORD(IDW), .CTYPE_WORD(CTW)) uut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .undef_acc(undef_acc),
        .cache_cmd_valid(cache_cmd_valid), .tlb_cmd_valid(tlb_cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .mmu_en(mmu_en), .align_chk_en(align_chk_en), .dcache_en(dcache_en),
        .big_endian(big_endian), .icache_en(icache_en), .vec_high(vec_high),
        .rr_repl(rr_repl), .ttb_base(ttb_base), .domain_acl(domain_acl), .proc_id(proc_id)
    );

    // kind: 0 no strobe, 1 read result, 2 cache command, 3 TLB command
    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [3:0]  crn;
        logic [3:0]  crm;
        logic [2:0]  op2;
        logic [31:0] data;
        logic [1:0]  kind;
        logic [31:0] exp;
        logic [3:0]  op;
        logic        undef;
    } vec_t;

    localparam int NV = 48;
    localparam vec_t TBL [NV] = '{
        '{4'd1, 1'b0, 4'd0, 4'd0, 3'd0, 32'h0, 2'd1, IDW, 4'd0, 1'b0},            // R1
        '{4'd1, 1'b0, 4'd0, 4'd0, 3'd1, 32'h0, 2'd1, CTW, 4'd0, 1'b0},            // R1
        '{4'd1, 1'b0, 4'd0, 4'd0, 3'd5, 32'h0, 2'd1, IDW, 4'd0, 1'b0},            // R1
        '{4'd1, 1'b1, 4'd0, 4'd0, 3'd1, 32'hFFFF_FFFF, 2'd0, 32'h0, 4'd0, 1'b0},  // R1
        '{4'd1, 1'b0, 4'd0, 4'd0, 3'd1, 32'h0, 2'd1, CTW, 4'd0, 1'b0},            // R1
        '{4'd3, 1'b0, 4'd1, 4'd0, 3'd0, 32'h0, 2'd1, 32'h0000_0078, 4'd0, 1'b0},  // R3
        '{4'd3, 1'b1, 4'd1, 4'd0, 3'd0, 32'hFFFF_FFFF, 2'd0, 32'h0, 4'd0, 1'b0},  // R3
        '{4'd3, 1'b0, 4'd1, 4'd0, 3'd0, 32'h0, 2'd1, 32'hC000_73FF, 4'd0, 1'b0},  // R3
        '{4'd3, 1'b1, 4'd1, 4'd0, 3'd0, 32'h0, 2'd0, 32'h0, 4'd0, 1'b0},          // R3
        '{4'd3, 1'b0, 4'd1, 4'd0, 3'd0, 32'h0, 2'd1, 32'h0000_0078, 4'd0, 1'b0},  // R3
        '{4'd5, 1'b1, 4'd2, 4'd0, 3'd0, 32'h1234_5678, 2'd0, 32'h0, 4'd0, 1'b0},  // R5
        '{4'd5, 1'b0, 4'd2, 4'd0, 3'd0, 32'h0, 2'd1, 32'h1234_5678, 4'd0, 1'b0},  // R5
        '{4'd5, 1'b1, 4'd3, 4'd0, 3'd0, 32'hA5A5_0F0F, 2'd0, 32'h0, 4'd0, 1'b0},  // R5
        '{4'd5, 1'b0, 4'd3, 4'd0, 3'd0, 32'h0, 2'd1, 32'hA5A5_0F0F, 4'd0, 1'b0},  // R5
        '{4'd5, 1'b1, 4'd6, 4'd0, 3'd0, 32'hDEAD_BEEF, 2'd0, 32'h0, 4'd0, 1'b0},  // R5
        '{4'd5, 1'b0, 4'd6, 4'd0, 3'd0, 32'h0, 2'd1, 32'hDEAD_BEEF, 4'd0, 1'b0},  // R5
        '{4'd6, 1'b1, 4'd5, 4'd0, 3'd0, 32'hFFFF_FF3C, 2'd0, 32'h0, 4'd0, 1'b0},  // R6
        '{4'd6, 1'b1, 4'd5, 4'd0, 3'd1, 32'h1234_5681, 2'd0, 32'h0, 4'd0, 1'b0},  // R6
        '{4'd6, 1'b0, 4'd5, 4'd0, 3'd0, 32'h0, 2'd1, 32'h0000_003C, 4'd0, 1'b0},  // R6
        '{4'd6, 1'b0, 4'd5, 4'd0, 3'd1, 32'h0, 2'd1, 32'h0000_0081, 4'd0, 1'b0},  // R6
        '{4'd11, 1'b0, 4'd5, 4'd0, 3'd2, 32'h0, 2'd1, 32'h0, 4'd0, 1'b1},         // R11
        '{4'd7, 1'b0, 4'd13, 4'd0, 3'd0, 32'h0, 2'd1, 32'h0, 4'd0, 1'b0},         // R7
        '{4'd7, 1'b1, 4'd13, 4'd0, 3'd0, 32'hFFFF_FFFF, 2'd0, 32'h0, 4'd0, 1'b0}, // R7
        '{4'd7, 1'b0, 4'd13, 4'd0, 3'd0, 32'h0, 2'd1, 32'hFE00_0000, 4'd0, 1'b0}, // R7
        '{4'd8, 1'b0, 4'd9, 4'd0, 3'd0, 32'h0, 2'd1, 32'h0, 4'd0, 1'b0},          // R8
        '{4'd8, 1'b1, 4'd9, 4'd0, 3'd0, 32'h1111_0000, 2'd0, 32'h0, 4'd0, 1'b0},  // R8
        '{4'd8, 1'b1, 4'd9, 4'd0, 3'd1, 32'h2222_0001, 2'd0, 32'h0, 4'd0, 1'b0},  // R8
        '{4'd8, 1'b0, 4'd9, 4'd0, 3'd0, 32'h0, 2'd1, 32'h1111_0000, 4'd0, 1'b0},  // R8
        '{4'd8, 1'b0, 4'd9, 4'd0, 3'd1, 32'h0, 2'd1, 32'h2222_0001, 4'd0, 1'b0},  // R8
        '{4'd8, 1'b1, 4'd10, 4'd0, 3'd1, 32'hC000_0001, 2'd0, 32'h0, 4'd0, 1'b0}, // R8
        '{4'd8, 1'b0, 4'd10, 4'd0, 3'd0, 32'h0, 2'd1, 32'h0, 4'd0, 1'b0},         // R8
        '{4'd8, 1'b0, 4'd10, 4'd0, 3'd1, 32'h0, 2'd1, 32'hC000_0001, 4'd0, 1'b0}, // R8
        '{4'd9, 1'b1, 4'd7, 4'd7, 3'd0, 32'h0000_0100, 2'd2, 32'h0000_0100, 4'd1, 1'b0},   // R9
        '{4'd9, 1'b1, 4'd7, 4'd10, 3'd4, 32'h0, 2'd2, 32'h0, 4'd11, 1'b0},                 // R9
        '{4'd9, 1'b1, 4'd7, 4'd14, 3'd2, 32'h0000_0040, 2'd2, 32'h0000_0040, 4'd10, 1'b0}, // R9
        '{4'd9, 1'b1, 4'd7, 4'd0, 3'd4, 32'h7, 2'd2, 32'h7, 4'd12, 1'b0},                  // R9
        '{4'd9, 1'b1, 4'd7, 4'd13, 3'd1, 32'h0000_2000, 2'd2, 32'h0000_2000, 4'd4, 1'b0},  // R9
        '{4'd9, 1'b1, 4'd7, 4'd5, 3'd1, 32'h0000_3FE0, 2'd2, 32'h0000_3FE0, 4'd3, 1'b0},   // R9
        '{4'd10, 1'b1, 4'd7, 4'd3, 3'd0, 32'h55, 2'd0, 32'h0, 4'd0, 1'b0},                 // R10
        '{4'd10, 1'b1, 4'd8, 4'd7, 3'd0, 32'h0, 2'd3, 32'h0, 4'd1, 1'b0},                  // R10
        '{4'd10, 1'b1, 4'd8, 4'd6, 3'd1, 32'h8000_1000, 2'd3, 32'h8000_1000, 4'd5, 1'b0},  // R10
        '{4'd10, 1'b1, 4'd8, 4'd7, 3'd1, 32'h99, 2'd0, 32'h0, 4'd0, 1'b0},                 // R10
        '{4'd11, 1'b0, 4'd7, 4'd0, 3'd0, 32'h0, 2'd1, 32'h0, 4'd0, 1'b1},         // R11
        '{4'd11, 1'b0, 4'd8, 4'd0, 3'd0, 32'h0, 2'd1, 32'h0, 4'd0, 1'b1},         // R11
        '{4'd11, 1'b0, 4'd15, 4'd0, 3'd0, 32'h0, 2'd1, 32'h0, 4'd0, 1'b1},        // R11
        '{4'd11, 1'b1, 4'd4, 4'd0, 3'd0, 32'h1, 2'd0, 32'h0, 4'd0, 1'b1},         // R11
        '{4'd11, 1'b1, 4'd9, 4'd0, 3'd3, 32'hFFFF_FFFF, 2'd0, 32'h0, 4'd0, 1'b1}, // R11
        '{4'd11, 1'b0, 4'd9, 4'd0, 3'd0, 32'h0, 2'd1, 32'h1111_0000, 4'd0, 1'b0}  // R11
    };

    task automatic note(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [3:0] crn, input logic [3:0] crm,
                         input logic [2:0] op2, input logic [31:0] d);
        acc_valid = 1'b1; acc_write = wr; acc_crn = crn;
        acc_crm = crm; acc_op2 = op2; acc_wdata = d;
    endtask

    task automatic idle();
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R4 R5: reset state at the ports
        note({rd_valid, undef_acc, cache_cmd_valid, tlb_cmd_valid} == 4'b0, "R2", "idle strobes",
             64'({rd_valid, undef_acc, cache_cmd_valid, tlb_cmd_valid}), 64'h0);
        note({mmu_en, align_chk_en, dcache_en, big_endian, icache_en, vec_high, rr_repl} == 7'b0,
             "R4", "reset enables",
             64'({mmu_en, align_chk_en, dcache_en, big_endian, icache_en, vec_high, rr_repl}), 64'h0);
        note(ttb_base == 0 && domain_acl == 0 && proc_id == 0, "R5", "reset words",
             {ttb_base, domain_acl}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            logic ok;
            logic er, ec, et;
            drive(TBL[i].wr, TBL[i].crn, TBL[i].crm, TBL[i].op2, TBL[i].data);
            @(negedge clk);
            idle();
            er = (TBL[i].kind == 2'd1);
            ec = (TBL[i].kind == 2'd2);
            et = (TBL[i].kind == 2'd3);
            ok = (rd_valid == er) && (cache_cmd_valid == ec) && (tlb_cmd_valid == et)
                 && (undef_acc == TBL[i].undef)
                 && (!er || rd_data == TBL[i].exp)
                 && (!(ec || et) || (cmd_addr == TBL[i].exp && cmd_op == TBL[i].op));
            checks++;
            if (!ok) begin
                fails++;
                $display("FAIL R%0d vec %0d actual=v%b u%b c%b t%b d=%h op=%0d a=%h expected=k%0d u%b d=%h op=%0d",
                         TBL[i].req, i, rd_valid, undef_acc, cache_cmd_valid, tlb_cmd_valid,
                         rd_data, cmd_op, cmd_addr, TBL[i].kind, TBL[i].undef, TBL[i].exp, TBL[i].op);
            end
        end

        // R4: control bits drive the enables
        drive(1'b1, 4'd1, 4'd0, 3'd0, 32'h0000_3085);
        @(negedge clk); idle();
        note({mmu_en, align_chk_en, dcache_en, big_endian, icache_en, vec_high, rr_repl} == 7'b1011110,
             "R4", "enables A",
             64'({mmu_en, align_chk_en, dcache_en, big_endian, icache_en, vec_high, rr_repl}), 64'h5E);
        drive(1'b1, 4'd1, 4'd0, 3'd0, 32'h0000_4002);
        @(negedge clk); idle();
        note({mmu_en, align_chk_en, dcache_en, big_endian, icache_en, vec_high, rr_repl} == 7'b0100001,
             "R4", "enables B",
             64'({mmu_en, align_chk_en, dcache_en, big_endian, icache_en, vec_high, rr_repl}), 64'h21);

        // R5: output words follow stored state
        note(ttb_base == 32'h1234_5678 && domain_acl == 32'hA5A5_0F0F, "R5", "ttb/dacr ports",
             {ttb_base, domain_acl}, 64'h1234_5678_A5A5_0F0F);
        // R7: identifier port holds the top seven bits
        note(proc_id == 7'h7F, "R7", "pid port", 64'(proc_id), 64'h7F);

        // R2: back-to-back reads, then valid drops
        drive(1'b0, 4'd2, 4'd0, 3'd0, 32'h0);
        @(negedge clk);
        note(rd_valid && rd_data == 32'h1234_5678, "R2", "first of pair",
             {31'h0, rd_valid, rd_data}, {32'h1, 32'h1234_5678});
        drive(1'b0, 4'd6, 4'd0, 3'd0, 32'h0);
        @(negedge clk); idle();
        note(rd_valid && rd_data == 32'hDEAD_BEEF, "R2", "second of pair",
             {31'h0, rd_valid, rd_data}, {32'h1, 32'hDEAD_BEEF});
        @(negedge clk);
        note(!rd_valid, "R2", "valid drops", 64'(rd_valid), 64'h0);

        // R3: write then immediate read sees the masked value
        drive(1'b1, 4'd1, 4'd0, 3'd0, 32'h0000_0C00);
        @(negedge clk);
        drive(1'b0, 4'd1, 4'd0, 3'd0, 32'h0);
        @(negedge clk); idle();
        note(rd_valid && rd_data == 32'h0000_0078, "R3", "bits 11:10 dropped",
             64'(rd_data), 64'h78);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule